// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block steps a successive-approximation A/D converter through one conversion. A one-tick start pulse launches the conversion. The block then opens the sampling switch, presents one trial code after another to the DAC, and strobes the comparator once per bit. When the last bit is resolved it runs a closing processing phase, loads the result register and pulses done. The comparator, the DAC and the capacitor array stay outside the block. The block sees only the comparator decision, `cmp_above_i`, which is 1 when the analog input is at or above the trial level.

The block is clocked at twice the conversion-clock rate, so each tick is half a conversion cycle and the 2.5-cycle phases become whole counts. Phase lengths in ticks depend on the hold mode (`sh_en_i`, 1 = sample-and-hold used).

| Phase | Without hold | With hold |
|---|---|---|
| Opening sample | 8 | 8 |
| First-bit compare | 4 | 5 |
| Per-bit sample, later bits | 5 | 0 |
| Compare, later bits | 5 | 5 |
| Closing processing | 16 | 8 |

`res10_i` selects the resolution (1 = 10 bits, 0 = 8 bits). The resolution and the hold mode are captured at the start pulse and kept for the whole conversion.

The states are IDLE, SAMPLE, COMPARE and FINISH. The transitions are:
- IDLE→SAMPLE on a start pulse.
- SAMPLE→COMPARE when the phase timer expires.
- COMPARE→SAMPLE after a non-final bit without hold.
- COMPARE→COMPARE after a non-final bit with hold.
- COMPARE→FINISH after bit 0.
- FINISH→IDLE when the closing phase expires.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `sample_en_o` and `cmp_strobe_o` are 0 and `result_o` is 0.
- R2: A conversion keeps `busy_o` high for exactly 98 ticks (8-bit, no hold), 118 (10-bit, no hold), 56 (8-bit, hold) or 66 (10-bit, hold). Busy starts on the tick after the edge that takes the start pulse.
- R3: `sample_en_o` is high only inside busy. It is high for all of the first 8 busy ticks. Its total per conversion is 8 + 5·(bits−1) ticks without hold and 8 ticks with hold.
- R4: `cmp_strobe_o` is high for exactly one tick per bit (8 or 10 per conversion). It is never high together with `sample_en_o`, and never on two consecutive ticks.
- R5: While bit k is strobed, `trial_o` equals the bits above k already resolved, plus bit k set to 1, with all bits below k at 0. The MSB is bit 7 at 8-bit resolution and bit 9 at 10-bit resolution.
- R6: Bit k of the result takes the value of `cmp_above_i` on its strobe tick. With a comparator that reports input ≥ trial, the result equals the input code, right-aligned, with the upper two bits 0 at 8-bit resolution.
- R7: `done_o` is high for exactly one tick: the first tick on which `busy_o` is low again. `result_o` changes only on that tick and holds otherwise.
- R8: A start pulse while busy is ignored: the length and the result of the running conversion are unchanged.
- R9: Changes on `res10_i` or `sh_en_i` during a conversion do not alter its timing or result.
- R10: Reset during a conversion returns the block to idle, with `busy_o` low and `result_o` cleared.
- R11: The first strobe falls on busy tick 11 (counted from 0) without hold and on busy tick 12 with hold.
- R12: After the last strobe, `busy_o` stays high for 16 more ticks without hold and 8 with hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Twice-conversion-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when idle |
| res10_i | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| sh_en_i | input | 1 | 1 = sample-and-hold timing |
| cmp_above_i | input | 1 | Comparator: input at or above trial level |
| sample_en_o | output | 1 | Sampling switch enable |
| cmp_strobe_o | output | 1 | Comparator decision tick |
| trial_o | output | 10 | Trial code to the DAC |
| result_o | output | 10 | Last completed conversion result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-tick completion pulse |

## Verification
The bench runs all four mode combinations against the input codes 0, full scale, alternating patterns and exact half scale. It counts busy, sampling and strobe ticks, so an off-by-one in any phase load, or a wrong first-compare or closing length, shows up as a total that misses 98/118/56/66 or a misplaced first or last strobe. A trial code that forgets resolved bits, or that sets the wrong bit, fails the per-strobe trial comparison and gives a wrong result. Start pulses and mode flips are injected in the middle of a run. A design that re-arms on them, or that decodes the live mode pins, would stretch the run or re-time it. A reset in the middle of a run must leave the block idle with the result cleared.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_COMPARE = 2'd2,
        ST_FINISH  = 2'd3
    } sar_state_e;
endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int BITS  = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             active_i,
    input  logic             decide_i,
    input  logic             keep_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [BITS-1:0]  trial_o,
    output logic [BITS-1:0]  resolved_o
);
    logic [BITS-1:0] res_q;

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        logic hit;
        assign hit = (idx_i == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                res_q[i] <= 1'b0;
            else if (clear_i)
                res_q[i] <= 1'b0;
            else if (decide_i && hit)
                res_q[i] <= keep_i;
        end

        assign trial_o[i] = res_q[i] | (active_i & hit);
    end

    assign resolved_o = res_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
    parameter int MAX_BITS       = 10,
    parameter int LOW_BITS       = 8,
    parameter int T_SAMP_FIRST   = 8,
    parameter int T_CMP1_DIRECT  = 4,
    parameter int T_CMP1_HOLD    = 5,
    parameter int T_SAMP_NEXT    = 5,
    parameter int T_CMP_NEXT     = 5,
    parameter int T_END_DIRECT   = 16,
    parameter int T_END_HOLD     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                res10_i,
    input  logic                sh_en_i,
    input  logic                cmp_above_i,
    output logic                sample_en_o,
    output logic                cmp_strobe_o,
    output logic [MAX_BITS-1:0] trial_o,
    output logic [MAX_BITS-1:0] result_o,
    output logic                busy_o,
    output logic                done_o
);
    import sar_seq_pkg::*;

    localparam int M1 = (T_SAMP_FIRST > T_CMP1_DIRECT) ? T_SAMP_FIRST : T_CMP1_DIRECT;
    localparam int M2 = (M1 > T_CMP1_HOLD) ? M1 : T_CMP1_HOLD;
    localparam int M3 = (M2 > T_SAMP_NEXT) ? M2 : T_SAMP_NEXT;
    localparam int M4 = (M3 > T_CMP_NEXT) ? M3 : T_CMP_NEXT;
    localparam int M5 = (M4 > T_END_DIRECT) ? M4 : T_END_DIRECT;
    localparam int LONGEST = (M5 > T_END_HOLD) ? M5 : T_END_HOLD;
    localparam int CNT_W = (LONGEST > 2) ? $clog2(LONGEST) : 1;
    localparam int IDX_W = $clog2(MAX_BITS);

    sar_state_e        state_q, state_d;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              last;
    logic [IDX_W-1:0]  idx_q;
    logic              first_q;
    logic              sh_q;
    logic              res10_q;
    logic              done_q;
    logic [MAX_BITS-1:0] result_q;
    logic [MAX_BITS-1:0] resolved;
    logic              take_start;
    logic              bit_done;
    logic              final_bit;
    logic              conv_end;
    logic              active;

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign bit_done   = (state_q == ST_COMPARE) && last;
    assign final_bit  = (idx_q == '0);
    assign conv_end   = (state_q == ST_FINISH) && last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and phase loads
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_SAMPLE;
                    load     = 1'b1;
                    load_val = CNT_W'(T_SAMP_FIRST - 1);
                end
            end
            ST_SAMPLE: begin
                if (last) begin
                    state_d  = ST_COMPARE;
                    load     = 1'b1;
                    if (first_q)
                        load_val = sh_q ? CNT_W'(T_CMP1_HOLD - 1) : CNT_W'(T_CMP1_DIRECT - 1);
                    else
                        load_val = CNT_W'(T_CMP_NEXT - 1);
                end
            end
            ST_COMPARE: begin
                if (last) begin
                    load = 1'b1;
                    if (final_bit) begin
                        state_d  = ST_FINISH;
                        load_val = sh_q ? CNT_W'(T_END_HOLD - 1) : CNT_W'(T_END_DIRECT - 1);
                    end else if (sh_q) begin
                        state_d  = ST_COMPARE;
                        load_val = CNT_W'(T_CMP_NEXT - 1);
                    end else begin
                        state_d  = ST_SAMPLE;
                        load_val = CNT_W'(T_SAMP_NEXT - 1);
                    end
                end
            end
            ST_FINISH: begin
                if (last)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // conversion context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            first_q  <= 1'b0;
            sh_q     <= 1'b0;
            res10_q  <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= conv_end;
            if (take_start) begin
                sh_q    <= sh_en_i;
                res10_q <= res10_i;
                first_q <= 1'b1;
                idx_q   <= res10_i ? IDX_W'(MAX_BITS - 1) : IDX_W'(LOW_BITS - 1);
            end else if (bit_done && !final_bit) begin
                idx_q   <= idx_q - 1'b1;
                first_q <= 1'b0;
            end
            if (conv_end)
                result_q <= resolved;
        end
    end

    sar_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .last_o     (last)
    );

    sar_approx_reg #(.BITS(MAX_BITS), .IDX_W(IDX_W)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (take_start),
        .active_i   (active),
        .decide_i   (bit_done),
        .keep_i     (cmp_above_i),
        .idx_i      (idx_q),
        .trial_o    (trial_o),
        .resolved_o (resolved)
    );

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        sample_en_o  = (state_q == ST_SAMPLE);
        cmp_strobe_o = bit_done;
        active       = (state_q == ST_SAMPLE) || (state_q == ST_COMPARE);
        done_o       = done_q;
        result_o     = result_q;
    end

    // res10_q is kept for visibility of the captured mode; index load already used it
    logic unused_res10;
    assign unused_res10 = res10_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int MAX_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                sample_en_o,
    input logic                cmp_strobe_o,
    input logic [MAX_BITS-1:0] result_o,
    input logic                busy_o,
    input logic                done_o
);
    a_r3_sample_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |-> busy_o);

    a_r4_strobe_alone: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe_o |-> (busy_o && !sample_en_o));

    a_r4_strobe_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe_o |=> !cmp_strobe_o);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r7_result_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind sar_seq_top sar_seq_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sample_en_o  (sample_en_o),
    .cmp_strobe_o (cmp_strobe_o),
    .result_o     (result_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       res10_i = 1'b0;
    logic       sh_en_i = 1'b0;
    logic       cmp_above_i;
    logic       sample_en_o, cmp_strobe_o, busy_o, done_o;
    logic [9:0] trial_o, result_o;
    logic [9:0] ain = '0;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign cmp_above_i = (ain >= trial_o);

    sar_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .res10_i(res10_i),
        .sh_en_i(sh_en_i), .cmp_above_i(cmp_above_i), .sample_en_o(sample_en_o),
        .cmp_strobe_o(cmp_strobe_o), .trial_o(trial_o), .result_o(result_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(busy_o == 1'b0,       "R1 busy", busy_o, 0);
        chk(done_o == 1'b0,       "R1 done", done_o, 0);
        chk(sample_en_o == 1'b0,  "R1 sample", sample_en_o, 0);
        chk(cmp_strobe_o == 1'b0, "R1 strobe", cmp_strobe_o, 0);
        chk(result_o == 10'd0,    "R1 result", result_o, 0);
    endtask

    // one conversion; poke_t >= 0 injects a start pulse (and optionally a mode flip) at that busy tick
    task automatic t_conv(input logic r10, input logic sh, input logic [9:0] code,
                          input int poke_t, input bit poke_mode, input string tag);
        int bits = r10 ? 10 : 8;
        int msb = bits - 1;
        int exp_t = sh ? (8 + 5 + 5 * (bits - 1) + 8) : (8 + 4 + 10 * (bits - 1) + 16);
        int exp_samp = sh ? 8 : 8 + 5 * (bits - 1);
        int exp_first = sh ? 12 : 11;
        int exp_end = sh ? 8 : 16;
        int nb = 0, nsamp = 0, nstr = 0, first_s = -1, last_s = -1, trial_bad = 0;
        bit early_ok = 1'b1;
        logic [9:0] exp_res = '0;
        logic [9:0] exp_trial;
        logic [9:0] held;
        ain = code;
        @(negedge clk);
        res10_i = r10; sh_en_i = sh; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o && nb < 400) begin
            if (sample_en_o) nsamp++;
            if (nb < 8 && !sample_en_o) early_ok = 1'b0;
            if (cmp_strobe_o) begin
                if (first_s < 0) first_s = nb;
                last_s = nb;
                exp_trial = exp_res | (10'd1 << (msb - nstr));
                if (trial_o != exp_trial) begin
                    trial_bad++;
                    chk(1'b0, {"R5 trial ", tag}, trial_o, exp_trial);
                end
                if (ain >= exp_trial) exp_res = exp_trial;
                nstr++;
            end
            if (nb == poke_t) begin
                start_i = 1'b1;
                if (poke_mode) begin res10_i = ~r10; sh_en_i = ~sh; end
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            nb++;
        end
        start_i = 1'b0; res10_i = r10; sh_en_i = sh;
        chk(nb == exp_t,           {"R2 busy ticks ", tag}, nb, exp_t);
        chk(nsamp == exp_samp,     {"R3 sample ticks ", tag}, nsamp, exp_samp);
        chk(early_ok,              {"R3 opening sample ", tag}, early_ok, 1);
        chk(nstr == bits,          {"R4 strobes ", tag}, nstr, bits);
        chk(trial_bad == 0,        {"R5 trial codes ", tag}, trial_bad, 0);
        chk(first_s == exp_first,  {"R11 first strobe ", tag}, first_s, exp_first);
        chk(nb - 1 - last_s == exp_end, {"R12 closing ticks ", tag}, nb - 1 - last_s, exp_end);
        chk(done_o == 1'b1,        {"R7 done at end ", tag}, done_o, 1);
        chk(result_o == exp_res,   {"R6 result model ", tag}, result_o, exp_res);
        chk(result_o == code,      {"R6 result code ", tag}, result_o, code);
        held = result_o;
        @(negedge clk);
        chk(done_o == 1'b0,        {"R7 done one tick ", tag}, done_o, 0);
        chk(result_o == held,      {"R7 result held ", tag}, result_o, held);
    endtask

    task automatic t_ignore_start();
        t_conv(1'b1, 1'b0, 10'h155, 40, 1'b0, "R8 start while busy direct");
        t_conv(1'b0, 1'b1, 10'h0A5, 20, 1'b0, "R8 start while busy hold");
    endtask

    task automatic t_mode_hold();
        t_conv(1'b0, 1'b0, 10'h03C, 30, 1'b1, "R9 mode flip direct8");
        t_conv(1'b1, 1'b1, 10'h2F1, 15, 1'b1, "R9 mode flip hold10");
    endtask

    task automatic t_reset_midrun();
        t_conv(1'b0, 1'b1, 10'h0FF, -1, 1'b0, "R10 preload");
        @(negedge clk);
        ain = 10'h123; res10_i = 1'b1; sh_en_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0,      "R10 busy after reset", busy_o, 0);
        chk(result_o == 10'd0,   "R10 result cleared", result_o, 0);
        chk(sample_en_o == 1'b0, "R10 sample off", sample_en_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_conv(1'b1, 1'b0, 10'h123, -1, 1'b0, "R10 after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_conv(1'b0, 1'b0, 10'h000, -1, 1'b0, "direct8 zero");
        t_conv(1'b0, 1'b0, 10'h0FF, -1, 1'b0, "direct8 full");
        t_conv(1'b1, 1'b0, 10'h2AA, -1, 1'b0, "direct10 alt");
        t_conv(1'b1, 1'b0, 10'h3FF, -1, 1'b0, "direct10 full");
        t_conv(1'b0, 1'b1, 10'h080, -1, 1'b0, "hold8 half");
        t_conv(1'b0, 1'b1, 10'h055, -1, 1'b0, "hold8 alt");
        t_conv(1'b1, 1'b1, 10'h200, -1, 1'b0, "hold10 half");
        t_conv(1'b1, 1'b1, 10'h000, -1, 1'b0, "hold10 zero");
        t_ignore_start();
        t_mode_hold();
        t_reset_midrun();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule